// File: doc/BRIEF.md
# Message-Signaled Interrupt Receiver

This block sits on the upstream write path of a host bridge. Every upstream memory write passes through it. A write whose address falls in the interrupt window, where bits 31:20 equal 0xFEE, is taken as an interrupt message. The low bits of its write data are stored as a vector, and a request line toward a processor core is raised. Every other write goes out unchanged on a pass-through port. Both kinds of write use one valid/ready handshake.

Received vectors wait in a small first-in first-out store, oldest first. The core gets them in one of two ways, chosen by a mode input.

- In the base mode, the core pulses a read strobe on an acknowledge register. One cycle later it receives the oldest vector, and that vector is removed from the store.
- In the low-latency mode, the oldest vector is driven on a vector bus alongside the request. The core pulses an accept input to consume it, so no read is needed.

A message that arrives while the store is full is lost, and a sticky overflow flag records the loss.

Top module: `msi_rx_ctrl`

## Requirements
- R1: A write with `wr_addr[31:20] == 12'hFEE` is an interrupt message: it is never forwarded (`fwd_valid` stays low) and `wr_ready` is high for it.
- R2: Any other write appears unchanged on `fwd_addr`/`fwd_data` with `fwd_valid` high in the same cycle, and `wr_ready` then equals `fwd_ready`.
- R3: An accepted message stores `wr_data[7:0]` as its vector. Vectors leave the 8-entry store in arrival order.
- R4: `irq_req` is high exactly when the store holds at least one vector, starting the cycle after the first message is accepted.
- R5: In the base mode (`mode_direct` = 0), an `ack_rd` pulse gives `ack_valid` high for one cycle on the next cycle, with `ack_data` equal to the oldest vector, and that vector is removed.
- R6: A base-mode `ack_rd` while the store is empty returns `ack_data` = 8'hFF (spurious vector) and removes nothing.
- R7: In the low-latency mode (`mode_direct` = 1), `irq_vec` shows the oldest vector while `irq_req` is high. An `irq_accept` pulse removes that vector.
- R8: `ack_rd` has no effect in the low-latency mode: no `ack_valid` and no removal. `irq_accept` has no effect in the base mode, and there `irq_vec` reads 0.
- R9: A message that arrives when 8 vectors are held, in a cycle without a removal, is discarded. It sets `ovf_flag`, which stays high until reset.
- R10: After reset, `irq_req`, `ack_valid` and `ovf_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Upstream write valid |
| wr_ready | output | 1 | Upstream write accepted |
| wr_addr | input | 32 | Upstream write address |
| wr_data | input | 32 | Upstream write data |
| fwd_valid | output | 1 | Pass-through write valid |
| fwd_ready | input | 1 | Pass-through sink ready |
| fwd_addr | output | 32 | Pass-through write address |
| fwd_data | output | 32 | Pass-through write data |
| mode_direct | input | 1 | 1 selects low-latency delivery |
| ack_rd | input | 1 | Acknowledge register read strobe |
| ack_valid | output | 1 | Acknowledge read data valid |
| ack_data | output | 8 | Acknowledge read data (vector or 0xFF) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector shown with the request in low-latency mode |
| irq_accept | input | 1 | Core consumes the shown vector |
| ovf_flag | output | 1 | Sticky lost-message flag |

## Verification
The bench first runs directed sequences:
- nine messages against an 8-entry store, which separates storage from dropping;
- a drain by acknowledge reads beyond empty, which shows both arrival order and the spurious value;
- mode swaps with vectors pending, which show that each mode ignores the other's strobe.

Seeded random traffic then mixes addresses inside and outside the 0xFEE window, a randomly stalling pass-through sink, and random read, accept and mode inputs. This covers cases the directed sequences do not reach, such as a push and a removal in the same cycle on a full store, and the forwarding handshake under back-pressure.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  localparam int unsigned MSI_ADDR_W   = 32;
  localparam int unsigned MSI_DATA_W   = 32;
  localparam int unsigned MSI_VEC_W    = 8;
  localparam int unsigned MSI_DEPTH    = 8;
  localparam int unsigned MSI_WIN_LSB  = 20;
  localparam logic [11:0] MSI_WIN_TAG  = 12'hFEE;
  localparam logic [7:0]  MSI_SPURIOUS = 8'hFF;

  typedef enum logic {
    DELIV_ACK_READ = 1'b0,
    DELIV_DIRECT   = 1'b1
  } deliv_mode_e;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WIN_LSB = 20,
  parameter logic [ADDR_W-WIN_LSB-1:0] WIN_TAG = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned TAG_W = ADDR_W - WIN_LSB;

  logic [TAG_W-1:0] tag;
  assign tag = addr[ADDR_W-1:WIN_LSB];
  assign hit = (tag == WIN_TAG);
endmodule

// File: rtl/msi_vec_fifo.sv
module msi_vec_fifo #(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [VEC_W-1:0] push_vec,
  input  logic             pop,
  output logic [VEC_W-1:0] head,
  output logic             empty,
  output logic             drop
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [VEC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic full, pop_ok, accept;

  assign empty  = (count == '0);
  assign full   = (count == FULL_CNT);
  assign pop_ok = pop & ~empty;
  assign accept = push & (~full | pop_ok);
  assign drop   = push & full & ~pop_ok;
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({accept, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/msi_deliver.sv
module msi_deliver
  import msi_rx_pkg::*;
#(
  parameter int unsigned VEC_W = 8,
  parameter logic [VEC_W-1:0] SPUR = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  deliv_mode_e      mode,
  input  logic             ack_rd,
  input  logic             irq_accept,
  input  logic             empty,
  input  logic [VEC_W-1:0] head,
  output logic             pop,
  output logic             ack_valid,
  output logic [VEC_W-1:0] ack_data,
  output logic [VEC_W-1:0] irq_vec
);
  logic ack_sel;

  assign ack_sel = (mode == DELIV_ACK_READ) & ack_rd;
  assign pop = ~empty & ((mode == DELIV_DIRECT) ? irq_accept : ack_rd);
  assign irq_vec = ((mode == DELIV_DIRECT) && !empty) ? head : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid <= 1'b0;
      ack_data  <= '0;
    end else begin
      ack_valid <= ack_sel;
      if (ack_sel) ack_data <= empty ? SPUR : head;
    end
  end
endmodule

// File: rtl/msi_rx_ctrl.sv
module msi_rx_ctrl
  import msi_rx_pkg::*;
#(
  parameter int unsigned ADDR_W  = MSI_ADDR_W,
  parameter int unsigned DATA_W  = MSI_DATA_W,
  parameter int unsigned VEC_W   = MSI_VEC_W,
  parameter int unsigned DEPTH   = MSI_DEPTH,
  parameter int unsigned WIN_LSB = MSI_WIN_LSB,
  parameter logic [ADDR_W-WIN_LSB-1:0] WIN_TAG = MSI_WIN_TAG,
  parameter logic [VEC_W-1:0] SPUR = MSI_SPURIOUS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  input  logic              mode_direct,
  input  logic              ack_rd,
  output logic              ack_valid,
  output logic [VEC_W-1:0]  ack_data,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_accept,
  output logic              ovf_flag
);
  logic             win_hit, msg_push, fifo_pop, fifo_empty, fifo_drop;
  logic [VEC_W-1:0] fifo_head;
  deliv_mode_e      mode;

  assign mode = mode_direct ? DELIV_DIRECT : DELIV_ACK_READ;

  msi_addr_decode #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .WIN_TAG(WIN_TAG)) u_dec (
    .addr(wr_addr), .hit(win_hit)
  );

  assign fwd_valid = wr_valid & ~win_hit;
  assign fwd_addr  = wr_addr;
  assign fwd_data  = wr_data;
  assign wr_ready  = win_hit | fwd_ready;
  assign msg_push  = wr_valid & win_hit;

  msi_vec_fifo #(.VEC_W(VEC_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(msg_push), .push_vec(wr_data[VEC_W-1:0]),
    .pop(fifo_pop), .head(fifo_head), .empty(fifo_empty), .drop(fifo_drop)
  );

  msi_deliver #(.VEC_W(VEC_W), .SPUR(SPUR)) u_dlv (
    .clk(clk), .rst(rst), .mode(mode), .ack_rd(ack_rd), .irq_accept(irq_accept),
    .empty(fifo_empty), .head(fifo_head), .pop(fifo_pop),
    .ack_valid(ack_valid), .ack_data(ack_data), .irq_vec(irq_vec)
  );

  assign irq_req = ~fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) ovf_flag <= 1'b0;
    else if (fifo_drop) ovf_flag <= 1'b1;
  end
endmodule

// File: rtl/msi_rx_ctrl_chk.sv
module msi_rx_ctrl_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned WIN_LSB = 20,
  parameter logic [ADDR_W-WIN_LSB-1:0] WIN_TAG = '1,
  parameter logic [VEC_W-1:0] SPUR = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic              mode_direct,
  input logic              ack_rd,
  input logic              ack_valid,
  input logic [VEC_W-1:0]  ack_data,
  input logic              irq_req,
  input logic              ovf_flag
);
  logic in_win;
  assign in_win = (wr_addr[ADDR_W-1:WIN_LSB] == WIN_TAG);

  // R1
  msg_not_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && in_win) |-> (!fwd_valid && wr_ready));

  // R2
  fwd_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !in_win) |-> (fwd_valid && (wr_ready == fwd_ready)));

  // R4
  push_raises_req_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && in_win) |=> irq_req);

  // R5
  ack_source_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(ack_rd && !mode_direct));

  // R6
  spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !$past(irq_req)) |-> (ack_data == SPUR));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);
endmodule

bind msi_rx_ctrl msi_rx_ctrl_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .WIN_LSB(WIN_LSB), .WIN_TAG(WIN_TAG), .SPUR(SPUR)
) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .mode_direct(mode_direct),
  .ack_rd(ack_rd), .ack_valid(ack_valid), .ack_data(ack_data),
  .irq_req(irq_req), .ovf_flag(ovf_flag)
);

// File: tb/msi_rx_ctrl_bench.sv
module msi_rx_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_valid, wr_ready, fwd_valid, fwd_ready;
  logic [31:0] wr_addr, wr_data, fwd_addr, fwd_data;
  logic        mode_direct, ack_rd, ack_valid, irq_req, irq_accept, ovf_flag;
  logic [7:0]  ack_data, irq_vec;

  int checks = 0;
  int fails  = 0;

  logic [7:0] q [8];
  int         cnt = 0;
  logic       m_ovf = 1'b0;
  logic       m_ackv = 1'b0;
  logic [7:0] m_ack = 8'h00;
  logic       m_spur = 1'b0;

  always #4 clk = ~clk;

  msi_rx_ctrl u_msi_rx_ctrl (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .fwd_valid(fwd_valid),
    .fwd_ready(fwd_ready), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
    .mode_direct(mode_direct), .ack_rd(ack_rd), .ack_valid(ack_valid),
    .ack_data(ack_data), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_accept(irq_accept), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic in_win(input logic [31:0] a);
    return a[31:20] == 12'hFEE;
  endfunction

  function automatic logic [7:0] exp_irq_vec(input logic md);
    return (md && cnt > 0) ? q[0] : 8'h00;
  endfunction

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] d,
                      input logic fr, input logic ak, input logic ac, input logic md);
    logic hit, push, pop, drop;
    @(negedge clk);
    chk("R4 irq_req", irq_req, (cnt > 0));
    if (mode_direct) chk("R7 irq_vec", irq_vec, exp_irq_vec(1'b1));
    else             chk("R8 irq_vec base", irq_vec, 8'h00);
    chk("R9 ovf_flag", ovf_flag, m_ovf);
    chk(m_ackv ? "R5 ack_valid" : "R8 ack_valid", ack_valid, m_ackv);
    if (m_ackv) chk(m_spur ? "R6 ack_data" : "R3 R5 ack_data", ack_data, m_ack);
    wr_valid = v; wr_addr = a; wr_data = d; fwd_ready = fr;
    ack_rd = ak; irq_accept = ac; mode_direct = md;
    #1;
    hit = in_win(a);
    chk(hit ? "R1 fwd_valid" : "R2 fwd_valid", fwd_valid, v & ~hit);
    chk(hit ? "R1 wr_ready" : "R2 wr_ready", wr_ready, hit | fr);
    if (v && !hit) begin
      chk("R2 fwd_addr", fwd_addr, a);
      chk("R2 fwd_data", fwd_data, d);
    end
    push = v & hit;
    pop  = (cnt > 0) && (md ? ac : ak);
    drop = push && cnt == 8 && !pop;
    m_ackv = ak & ~md;
    m_spur = (cnt == 0);
    m_ack  = (cnt > 0) ? q[0] : 8'hFF;
    if (pop) begin
      for (int i = 0; i < 7; i++) q[i] = q[i+1];
      cnt--;
    end
    if (push && !drop) begin
      q[cnt] = d[7:0];
      cnt++;
    end
    if (drop) m_ovf = 1'b1;
  endtask

  task automatic idle(input logic md);
    step(1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, md);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] ra;
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst = 1'b1; wr_valid = 0; wr_addr = 0; wr_data = 0; fwd_ready = 0;
    mode_direct = 0; ack_rd = 0; irq_accept = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10 reset state
    #1;
    chk("R10 irq_req", irq_req, 1'b0);
    chk("R10 ovf_flag", ovf_flag, 1'b0);
    chk("R10 ack_valid", ack_valid, 1'b0);

    // R1 R3 R9: nine messages into an 8-entry store
    for (int i = 0; i < 9; i++)
      step(1'b1, 32'hFEE0_1000 + i, 32'h100 + i * 7, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(1'b0);
    // R8: accept in base mode has no effect
    step(1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    // R5 R6: drain in order, then read past empty
    for (int i = 0; i < 10; i++) step(1'b0, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    idle(1'b0);
    // R2: pass-through with and without back-pressure
    step(1'b1, 32'h1234_5678, 32'hCAFE_0001, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'hFEF0_0000, 32'hCAFE_0002, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7 R8: low-latency delivery, ack read ignored
    step(1'b1, 32'hFEE0_0004, 32'h0000_0031, 1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b1, 32'hFEEF_FFFC, 32'h0000_0042, 1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b0, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1);
    idle(1'b1);
    step(1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1);
    idle(1'b1);
    step(1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1);
    idle(1'b1);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      ra = $urandom;
      if ($urandom_range(1, 0) == 1) ra[31:20] = 12'hFEE;
      else if (ra[31:20] == 12'hFEE) ra[31] = 1'b0;
      step($urandom_range(1, 0) == 1, ra, $urandom, $urandom_range(1, 0) == 1,
           $urandom_range(3, 0) == 0, $urandom_range(3, 0) == 0,
           (n / 200) % 2 == 1);
    end
    idle(1'b0);
    idle(1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule